// File: doc/BRIEF.md
# Paired Half-Word Add/Subtract ALU

This block is a 32-bit datapath slice that treats each operand as two independent signed 16-bit half-words. In one operation it adds the two upper halves and subtracts the lower half of operand B from the lower half of operand A. No carry or borrow crosses the boundary between the halves. Two option bits change the result. One clamps each half to the signed 16-bit range instead of letting it wrap. The other places the two 16-bit results in the opposite halves of the output word.

An operation is presented with `in_valid`, both operands and the two option bits. The result appears one clock later, registered, together with `out_valid` and one overflow flag for each operation. A decode stage would issue one operation per cycle and write `out_result` back to its register file.

Top module: `pair_addsub_alu`

## Requirements
- R1: With both options clear, `out_result[31:16]` equals `op_a[31:16] + op_b[31:16]` modulo 2^16.
- R2: With both options clear, `out_result[15:0]` equals `op_a[15:0] - op_b[15:0]` modulo 2^16. A carry or borrow in either half never reaches the other half (0x65678911 paired with itself gives 0xCACE0000).
- R3: With `sat_en`=1 and `swap_en`=0, each half that overflows as a signed 16-bit value is clamped on its own. Positive overflow gives 0x7FFF and negative overflow gives 0x8000. A half that does not overflow is unchanged (0x6769 + 0x69CF gives 0x7FFF in the upper half).
- R4: With `swap_en`=1 and `sat_en`=0, the sum occupies `out_result[15:0]` and the difference occupies `out_result[31:16]` (0x45678B6B paired with itself gives 0x00008ACE).
- R5: With both options set, each half is first clamped as in R3 and the halves are then placed as in R4.
- R6: `out_ovf_sum` is 1 exactly when the signed sum of the upper halves lies outside [-32768, 32767]. `out_ovf_diff` is 1 exactly when the signed difference of the lower halves lies outside that range. Both flags follow the operation, not the output position, and are reported whatever the option bits are.
- R7: `out_valid` is 1 in the cycle after a clock edge at which `in_valid` is 1, and 0 otherwise. The result and flags for that input are presented in that same cycle.
- R8: When `in_valid` is 0 at a clock edge, `out_result`, `out_ovf_sum` and `out_ovf_diff` keep their previous values.
- R9: While `rst_n` is 0 at a clock edge, `out_valid`, `out_result` and both flags are cleared to 0 (synchronous, active-low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands and options are valid this cycle |
| op_a | input | 32 | Operand A: two signed 16-bit halves |
| op_b | input | 32 | Operand B: two signed 16-bit halves |
| sat_en | input | 1 | Clamp each half to the signed 16-bit range |
| swap_en | input | 1 | Put the sum in the low half and the difference in the high half |
| out_valid | output | 1 | Registered result is new this cycle |
| out_result | output | 32 | Registered packed result |
| out_ovf_sum | output | 1 | Signed overflow of the upper-half addition |
| out_ovf_diff | output | 1 | Signed overflow of the lower-half subtraction |

## Verification
The bench starts with operands taken from known good results. One half produces a carry or borrow, which exposes any leak across the half boundary. Another half is clamped, and a third operation is swapped.

Next, every pairing of 0x0000, 0x0001, 0x7FFF, 0x8000 and 0xFFFF in each half is run under all four option settings. These values overflow the sum and the difference in both directions, and they separate a correct sign test from a wrong one. They also distinguish clamp-then-swap from swap-then-clamp.

Equal operands are also applied. They give a zero difference and a doubled sum. The last stage is a long run of random operands and options with idle gaps, which shows whether results are held between valid inputs.

// File: rtl/pair_alu_pkg.sv
`timescale 1ns/1ps
package pair_alu_pkg;

    // Which arithmetic a half-word lane performs.
    typedef enum logic {
        LANE_ADD = 1'b0,
        LANE_SUB = 1'b1
    } lane_op_e;

    // Default half-word width used by the paired ALU.
    localparam int DEFAULT_HALF_W = 16;

endpackage

// File: rtl/half_lane.sv
`timescale 1ns/1ps
module half_lane
    import pair_alu_pkg::*;
#(
    parameter int       W  = 16,
    parameter lane_op_e OP = LANE_ADD
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sat,
    output logic [W-1:0] res,
    output logic         ovf
);

    localparam logic [W-1:0] POS_LIMIT = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] NEG_LIMIT = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] raw;
    logic         same_sign_in;

    generate
        if (OP == LANE_ADD) begin : g_add
            always_comb begin
                raw          = x + y;
                same_sign_in = (x[W-1] == y[W-1]);
            end
        end else begin : g_sub
            always_comb begin
                raw          = x - y;
                same_sign_in = (x[W-1] != y[W-1]);
            end
        end
    endgenerate

    // On overflow the true result carries the sign of x, so x picks the clamp value.
    always_comb begin
        ovf = same_sign_in && (raw[W-1] != x[W-1]);
        if (sat && ovf) begin
            res = x[W-1] ? NEG_LIMIT : POS_LIMIT;
        end else begin
            res = raw;
        end
    end

endmodule

// File: rtl/half_placer.sv
`timescale 1ns/1ps
module half_placer #(
    parameter int W = 16
) (
    input  logic [W-1:0]   sum_h,
    input  logic [W-1:0]   diff_h,
    input  logic           swap,
    output logic [2*W-1:0] word
);

    always_comb begin
        if (swap) begin
            word = {diff_h, sum_h};
        end else begin
            word = {sum_h, diff_h};
        end
    end

endmodule

// File: rtl/pair_addsub_alu.sv
`timescale 1ns/1ps
module pair_addsub_alu
    import pair_alu_pkg::*;
#(
    parameter int HALF_W = DEFAULT_HALF_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [2*HALF_W-1:0]   op_a,
    input  logic [2*HALF_W-1:0]   op_b,
    input  logic                  sat_en,
    input  logic                  swap_en,
    output logic                  out_valid,
    output logic [2*HALF_W-1:0]   out_result,
    output logic                  out_ovf_sum,
    output logic                  out_ovf_diff
);

    localparam int WORD_W = 2 * HALF_W;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] result;
        logic              ovf_sum;
        logic              ovf_diff;
    } out_state_t;

    logic [HALF_W-1:0] sum_half;
    logic [HALF_W-1:0] diff_half;
    logic              sum_ovf;
    logic              diff_ovf;
    logic [WORD_W-1:0] packed_word;

    out_state_t st_d;
    out_state_t st_q;

    half_lane #(.W(HALF_W), .OP(LANE_ADD)) u_hi_add (
        .x   (op_a[WORD_W-1:HALF_W]),
        .y   (op_b[WORD_W-1:HALF_W]),
        .sat (sat_en),
        .res (sum_half),
        .ovf (sum_ovf)
    );

    half_lane #(.W(HALF_W), .OP(LANE_SUB)) u_lo_sub (
        .x   (op_a[HALF_W-1:0]),
        .y   (op_b[HALF_W-1:0]),
        .sat (sat_en),
        .res (diff_half),
        .ovf (diff_ovf)
    );

    half_placer #(.W(HALF_W)) u_place (
        .sum_h  (sum_half),
        .diff_h (diff_half),
        .swap   (swap_en),
        .word   (packed_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result   = packed_word;
            st_d.ovf_sum  = sum_ovf;
            st_d.ovf_diff = diff_ovf;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid    = st_q.valid;
    assign out_result   = st_q.result;
    assign out_ovf_sum  = st_q.ovf_sum;
    assign out_ovf_diff = st_q.ovf_diff;

endmodule

// File: rtl/pair_addsub_alu_chk.sv
`timescale 1ns/1ps
module pair_addsub_alu_chk #(
    parameter int HALF_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [2*HALF_W-1:0] op_a,
    input logic [2*HALF_W-1:0] op_b,
    input logic                sat_en,
    input logic                swap_en,
    input logic                out_valid,
    input logic [2*HALF_W-1:0] out_result,
    input logic                out_ovf_sum,
    input logic                out_ovf_diff
);

    localparam int WORD_W = 2 * HALF_W;
    localparam logic [HALF_W-1:0] POS_LIM = {1'b0, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] NEG_LIM = {1'b1, {(HALF_W-1){1'b0}}};

    // R1
    plain_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_en && !swap_en) |=>
        out_result[WORD_W-1:HALF_W] ==
            HALF_W'($past(op_a[WORD_W-1:HALF_W]) + $past(op_b[WORD_W-1:HALF_W])));

    // R2
    plain_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_en && !swap_en) |=>
        out_result[HALF_W-1:0] ==
            HALF_W'($past(op_a[HALF_W-1:0]) - $past(op_b[HALF_W-1:0])));

    // R3
    sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && !swap_en) |=>
        (!out_ovf_sum || out_result[WORD_W-1:HALF_W] == POS_LIM ||
                         out_result[WORD_W-1:HALF_W] == NEG_LIM));

    // R4
    swap_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !sat_en && swap_en) |=>
        out_result[HALF_W-1:0] ==
            HALF_W'($past(op_a[WORD_W-1:HALF_W]) + $past(op_b[WORD_W-1:HALF_W])));

    // R5
    sat_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && sat_en && swap_en) |=>
        (!out_ovf_diff || out_result[WORD_W-1:HALF_W] == POS_LIM ||
                          out_result[WORD_W-1:HALF_W] == NEG_LIM));

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_ovf_sum) && $stable(out_ovf_diff)));

endmodule

bind pair_addsub_alu pair_addsub_alu_chk #(.HALF_W(HALF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .op_a         (op_a),
    .op_b         (op_b),
    .sat_en       (sat_en),
    .swap_en      (swap_en),
    .out_valid    (out_valid),
    .out_result   (out_result),
    .out_ovf_sum  (out_ovf_sum),
    .out_ovf_diff (out_ovf_diff)
);

// File: tb/sim_pair_addsub_alu.sv
`timescale 1ns/1ps
module sim_pair_addsub_alu;

    typedef struct {
        logic [31:0] res;
        logic        ovs;
        logic        ovd;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        sat_en = 1'b0;
    logic        swap_en = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_ovf_sum;
    logic        out_ovf_diff;

    int   n_checks = 0;
    int   n_fails  = 0;
    exp_t q_exp[$];
    exp_t last_exp;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    pair_addsub_alu u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .op_a         (op_a),
        .op_b         (op_b),
        .sat_en       (sat_en),
        .swap_en      (swap_en),
        .out_valid    (out_valid),
        .out_result   (out_result),
        .out_ovf_sum  (out_ovf_sum),
        .out_ovf_diff (out_ovf_diff)
    );

    function automatic exp_t model(input logic [31:0] a, input logic [31:0] b,
                                   input logic sat, input logic swp);
        exp_t        e;
        int          s;
        int          d;
        logic [15:0] sh;
        logic [15:0] dh;
        s = int'($signed(a[31:16])) + int'($signed(b[31:16]));
        d = int'($signed(a[15:0])) - int'($signed(b[15:0]));
        e.ovs = (s > 32767) || (s < -32768);
        e.ovd = (d > 32767) || (d < -32768);
        sh = s[15:0];
        dh = d[15:0];
        if (sat && e.ovs) sh = (s > 0) ? 16'h7FFF : 16'h8000;
        if (sat && e.ovd) dh = (d > 0) ? 16'h7FFF : 16'h8000;
        e.res = swp ? {dh, sh} : {sh, dh};
        if (sat && swp)      e.tag = "R5";
        else if (swp)        e.tag = "R4";
        else if (sat)        e.tag = "R3";
        else                 e.tag = "R1/R2";
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_checks++;
        if (act !== exp_v) begin
            n_fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp_v);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] b,
                        input logic sat, input logic swp);
        @(negedge clk);
        in_valid = 1'b1;
        op_a     = a;
        op_b     = b;
        sat_en   = sat;
        swap_en  = swp;
        q_exp.push_back(model(a, b, sat, swp));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a     = $urandom;
            op_b     = $urandom;
        end
    endtask

    // Scoreboard monitor: samples on the falling edge, away from the register update.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (q_exp.size() == 0) begin
                    n_checks++;
                    n_fails++;
                    $display("FAIL R7: actual out_valid 1 expected 0 (no pending input)");
                end else begin
                    exp_t e;
                    e = q_exp.pop_front();
                    check(e.tag, out_result, e.res);
                    check("R6", {30'd0, out_ovf_sum, out_ovf_diff}, {30'd0, e.ovs, e.ovd});
                    last_exp = e;
                end
            end else begin
                check("R8", {out_result}, last_exp.res);
                check("R8", {30'd0, out_ovf_sum, out_ovf_diff}, {30'd0, last_exp.ovs, last_exp.ovd});
            end
        end
    end

    task automatic reset_and_check();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9", out_result, 32'h0);
        check("R9", {29'd0, out_valid, out_ovf_sum, out_ovf_diff}, 32'h0);
        last_exp.res = '0;
        last_exp.ovs = 1'b0;
        last_exp.ovd = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] vals [5];
        exp_t        m;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
        vals[3] = 16'h8000; vals[4] = 16'hFFFF;
        last_exp.res = '0;
        last_exp.ovs = 1'b0;
        last_exp.ovd = 1'b0;
        last_exp.tag = "R8";

        // R9: reset state
        reset_and_check();

        // Reference sanity against known results (R2, R3, R4)
        m = model(32'h65678911, 32'h65678911, 1'b0, 1'b0);
        check("R2", m.res, 32'hCACE0000);
        m = model(32'h67690000, 32'h69CF0000, 1'b1, 1'b0);
        check("R3", {16'h0, m.res[31:16]}, 32'h00007FFF);
        m = model(32'h45678B6B, 32'h45678B6B, 1'b0, 1'b1);
        check("R4", m.res, 32'h00008ACE);

        // Directed vectors: cross-half carry/borrow, clamping, swapping
        send(32'h65678911, 32'h65678911, 1'b0, 1'b0);
        send(32'h9567892B, 32'hA789AB2D, 1'b0, 1'b0);
        send(32'h67694BCD, 32'h69CF3991, 1'b1, 1'b0);
        send(32'h45678B6B, 32'h45678B6B, 1'b0, 1'b1);
        send(32'h456739AB, 32'h69CF3991, 1'b1, 1'b1);
        send(32'h0000FFFF, 32'h00000001, 1'b0, 1'b0);
        idle(3);

        // R3/R5/R6: extreme halves under every option setting
        for (int opt = 0; opt < 4; opt++) begin
            for (int i = 0; i < 5; i++) begin
                for (int j = 0; j < 5; j++) begin
                    send({vals[i], vals[j]}, {vals[j], vals[i]}, opt[0], opt[1]);
                    send({vals[i], vals[j]}, {vals[i], vals[j]}, opt[0], opt[1]);
                end
            end
            idle(2);
        end

        // R9: reset in the middle of a run
        idle(3);
        reset_and_check();

        // Random operands, options and idle gaps (R1..R8)
        for (int k = 0; k < 400; k++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = $urandom;
            b = ($urandom_range(0, 7) == 0) ? a : $urandom;
            send(a, b, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
        end
        idle(4);

        // R7: every input produced exactly one result
        check("R7", q_exp.size(), 32'd0);
        finish_run();
    end

endmodule